// File: doc/BRIEF.md
# Byte-Wide EEPROM Page Programming Controller

This block is a clocked model of the control logic inside a byte-wide parallel EEPROM. An external bus drives active-low chip-select, output-enable and write-enable strobes together with an address and a data byte. The block samples all of them into its clock domain through a two-stage synchronizer. Write strobes deposit bytes into a page buffer of 2^PAGE_W bytes. The page is chosen at the start of the first strobe of a sequence, and only the in-page offset of later strobes is used.

If no further byte arrives within a load window, the block enters an internal programming period. During this period the busy output is raised, reads return status rather than stored data, and new loads are ignored. When the period ends, every byte that was loaded is committed to the storage array. Bytes of the page that were not loaded keep their old contents.

An active-low reset input aborts a load or a programming period in progress and floats the data output. After the reset input returns high, write strobes are refused for a recovery period. All durations are parameters counted in clock cycles. The array holds 2^ADDR_W bytes; ADDR_W = 15 gives the full 32768 x 8 organisation.

Top module: `eeprom_pgm_engine`

## Requirements
- R1: After the clock-domain reset, `busy_o` is 0, `dout_en_o` is 0 and every array byte reads 8'hFF.
- R2: A read is a strobe with `ce_n`=0, `oe_n`=0 and `we_n`=1. While it is held outside programming, `dout_en_o`=1 and `dout_o` equals the stored byte at `addr`.
- R3: A write strobe (`ce_n`=0, `we_n`=0, `oe_n`=1) captures `din` when it ends. The page (`addr[ADDR_W-1:PAGE_W]`) is taken at the start of the first strobe of a sequence. Later strobes use only `addr[PAGE_W-1:0]` and land in that page.
- R4: A write strobe seen with `oe_n`=0 loads nothing and starts no programming.
- R5: Programming begins T_BLW cycles after the last load has been registered, and each new load restarts this window. `busy_o` rises exactly T_BLW+3 clock edges after the final strobe release, counting the two synchronizer stages.
- R6: Programming lasts exactly T_PROG cycles. At its end, loaded bytes are written to the array and unloaded bytes of the page are unchanged.
- R7: During programming, `dout_o[7]` is the complement of bit 7 of the last loaded byte. After programming, it is the true stored bit.
- R8: During programming, `dout_o[6]` changes on every new read strobe.
- R9: Write strobes during programming are ignored and do not alter the array.
- R10: `busy_o` is 1 exactly while programming is in progress.
- R11: `res_n`=0 aborts loading or programming, clears `busy_o`, forces `dout_en_o` to 0 and leaves the array unchanged.
- R12: For T_REC cycles after `res_n` returns high, write strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and control clock |
| rst_n | input | 1 | Asynchronous active-low clock-domain reset |
| ce_n | input | 1 | Chip select strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| res_n | input | 1 | Program reset / write inhibit, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data byte driven by the bus on writes |
| dout | output | 8 | Read data or status byte |
| dout_en_o | output | 1 | Drive enable for `dout` (0 means high impedance) |
| busy_o | output | 1 | 1 while programming; pulls the ready/busy line low |

## Verification
The embedded properties check several things on every cycle. A reset always returns the engine to idle with busy cleared. Busy can only begin when the load timer has run out, and the program timer stays within its limit. The page buffer is frozen while busy, and a load always sets the matching valid bit. No load occurs during recovery, and a commit always places the buffered byte in the array. The exact cycle at which busy rises, the length of the busy period, the retriggering of the window, and the status bits seen on reads can only be shown by the bench scenarios. The same holds for the page-address capture, the inhibit by `oe_n`, and the fate of data after an abort or a refused write.

// File: rtl/eeprom_pgm_pkg.sv
package eeprom_pgm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } eng_state_e;
endpackage

// File: rtl/eeprom_strobe_sync.sv
module eeprom_strobe_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign sync_o = s2_q;
endmodule

// File: rtl/eeprom_page_latch.sv
module eeprom_page_latch #(
    parameter int PAGE_W = 6,
    localparam int NB    = 1 << PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 wr_i,
    input  logic [PAGE_W-1:0]    off_i,
    input  logic [7:0]           byte_i,
    output logic [NB-1:0][7:0]   data_o,
    output logic [NB-1:0]        vld_o
);
    logic [7:0] data_d [NB];
    logic [7:0] data_q [NB];
    logic       vld_d  [NB];
    logic       vld_q  [NB];

    for (genvar g = 0; g < NB; g++) begin : g_byte
        always_comb begin
            data_d[g] = data_q[g];
            vld_d[g]  = vld_q[g];
            if (clr_i) vld_d[g] = 1'b0;
            if (wr_i && off_i == PAGE_W'(g)) begin
                data_d[g] = byte_i;
                vld_d[g]  = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[g] <= 8'h00;
                vld_q[g]  <= 1'b0;
            end else begin
                data_q[g] <= data_d[g];
                vld_q[g]  <= vld_d[g];
            end
        end

        assign data_o[g] = data_q[g];
        assign vld_o[g]  = vld_q[g];
    end

    // R3
    load_marks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> vld_o[$past(off_i)]);
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
    parameter int ADDR_W  = 11,
    parameter int PAGE_W  = 6,
    localparam int NB     = 1 << PAGE_W,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int PSEL_W = ADDR_W - PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit_i,
    input  logic [PSEL_W-1:0]    page_i,
    input  logic [NB-1:0][7:0]   pdata_i,
    input  logic [NB-1:0]        pvld_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [7:0]           rd_data_o
);
    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) cell_q[a] <= 8'hFF;
        end else if (commit_i) begin
            for (int i = 0; i < NB; i++) begin
                if (pvld_i[i]) cell_q[{page_i, PAGE_W'(i)}] <= pdata_i[i];
            end
        end
    end

    assign rd_data_o = cell_q[rd_addr_i];

    // R6
    commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && pvld_i[0]) |=> cell_q[{$past(page_i), PAGE_W'(0)}] == $past(pdata_i[0]));
endmodule

// File: rtl/eeprom_pgm_engine.sv
module eeprom_pgm_engine #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 6,
    parameter int T_BLW  = 25000,
    parameter int T_PROG = 2500000,
    parameter int T_REC  = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              res_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en_o,
    output logic              busy_o
);
    import eeprom_pgm_pkg::*;

    localparam int NB     = 1 << PAGE_W;
    localparam int PSEL_W = ADDR_W - PAGE_W;
    localparam int MAXT   = (T_BLW > T_PROG) ? T_BLW : T_PROG;
    localparam int TMR_W  = $clog2(MAXT + 1);
    localparam int REC_W  = $clog2(T_REC + 1);
    localparam int SW     = 4 + ADDR_W + 8;

    typedef struct packed {
        eng_state_e        state;
        logic [TMR_W-1:0]  tmr;
        logic [REC_W-1:0]  rec;
        logic [PSEL_W-1:0] page;
        logic              armed;
        logic              last7;
        logic              tog;
        logic              wr_prev;
        logic              rd_prev;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [SW-1:0]     sync_w;
    logic              ce_s, oe_s, we_s, res_s;
    logic [ADDR_W-1:0] addr_s;
    logic [7:0]        din_s;

    eeprom_strobe_sync #(.W(SW), .RST_VAL({4'b1111, {(ADDR_W + 8){1'b0}}})) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({res_n, ce_n, oe_n, we_n, addr, din}),
        .sync_o  (sync_w)
    );
    assign {res_s, ce_s, oe_s, we_s, addr_s, din_s} = sync_w;

    logic                wr_act, rd_act, blocked;
    logic                wr_rise, wr_fall, rd_rise;
    logic                lat_wr, lat_clr, commit;
    logic [NB-1:0][7:0]  lat_data;
    logic [NB-1:0]       lat_vld;
    logic [7:0]          cell_rd;

    always_comb begin
        wr_act  = !ce_s && !we_s && oe_s && res_s;
        rd_act  = !ce_s && !oe_s && we_s;
        blocked = (eng_q.rec != '0) || !res_s;
        wr_rise = wr_act && !eng_q.wr_prev;
        wr_fall = !wr_act && eng_q.wr_prev;
        rd_rise = rd_act && !eng_q.rd_prev;

        eng_d         = eng_q;
        eng_d.wr_prev = wr_act;
        eng_d.rd_prev = rd_act;
        lat_wr        = 1'b0;
        lat_clr       = 1'b0;
        commit        = 1'b0;

        if (!res_s) begin
            eng_d.state = ST_IDLE;
            eng_d.tmr   = '0;
            eng_d.rec   = REC_W'(T_REC);
            eng_d.armed = 1'b0;
            lat_clr     = 1'b1;
        end else begin
            if (eng_q.rec != '0) eng_d.rec = eng_q.rec - 1'b1;
            unique case (eng_q.state)
                ST_IDLE: begin
                    if (wr_rise && !blocked) begin
                        eng_d.page  = addr_s[ADDR_W-1:PAGE_W];
                        eng_d.armed = 1'b1;
                    end
                    if (wr_fall && eng_q.armed && !blocked) begin
                        lat_wr      = 1'b1;
                        eng_d.last7 = din_s[7];
                        eng_d.state = ST_LOAD;
                        eng_d.tmr   = '0;
                        eng_d.armed = 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (wr_fall) begin
                        lat_wr      = 1'b1;
                        eng_d.last7 = din_s[7];
                        eng_d.tmr   = '0;
                    end else if (eng_q.tmr == TMR_W'(T_BLW - 1)) begin
                        eng_d.state = ST_PROG;
                        eng_d.tmr   = '0;
                    end else begin
                        eng_d.tmr = eng_q.tmr + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (rd_rise) eng_d.tog = !eng_q.tog;
                    if (eng_q.tmr == TMR_W'(T_PROG - 1)) begin
                        commit      = 1'b1;
                        lat_clr     = 1'b1;
                        eng_d.state = ST_IDLE;
                        eng_d.tmr   = '0;
                    end else begin
                        eng_d.tmr = eng_q.tmr + 1'b1;
                    end
                end
                default: eng_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{state: ST_IDLE, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    eeprom_page_latch #(.PAGE_W(PAGE_W)) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (lat_clr),
        .wr_i   (lat_wr),
        .off_i  (addr_s[PAGE_W-1:0]),
        .byte_i (din_s),
        .data_o (lat_data),
        .vld_o  (lat_vld)
    );

    eeprom_cell_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .page_i    (eng_q.page),
        .pdata_i   (lat_data),
        .pvld_i    (lat_vld),
        .rd_addr_i (addr_s),
        .rd_data_o (cell_rd)
    );

    assign busy_o    = (eng_q.state == ST_PROG);
    assign dout_en_o = rd_act && res_s;
    assign dout      = busy_o ? {!eng_q.last7, eng_q.tog, 6'b0} : cell_rd;

    // R11
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_s |=> (eng_q.state == ST_IDLE && !busy_o));

    // R5
    busy_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(eng_q.tmr) == TMR_W'(T_BLW - 1));

    // R6
    prog_time_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> eng_q.tmr < TMR_W'(T_PROG));

    // R9
    latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(lat_vld));

    // R12
    no_load_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.rec != '0) |-> !lat_wr);
endmodule

// File: tb/eeprom_pgm_engine_tb.sv
module eeprom_pgm_engine_tb_top;
    localparam int AW     = 11;
    localparam int T_BLW  = 20;
    localparam int T_PROG = 60;
    localparam int T_REC  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, res_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en_o, busy_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int rel   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eeprom_pgm_engine #(.ADDR_W(AW), .PAGE_W(6), .T_BLW(T_BLW), .T_PROG(T_PROG), .T_REC(T_REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .res_n(res_n),
        .addr(addr), .din(din), .dout(dout), .dout_en_o(dout_en_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic oe_v);
        @(negedge clk);
        addr = a; din = d; oe_n = oe_v; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        rel = cyc;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (3) @(negedge clk);
        d = dout; en = dout_en_o;
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_busy(input logic lvl, output int at);
        at = -1;
        for (int k = 0; k < 400; k++) begin
            if (busy_o == lvl) begin
                at = cyc;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d; logic en;
        chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
        chk(dout_en_o == 1'b0, "R1 output floating after reset", dout_en_o, 0);
        rd(11'h005, d, en);
        chk(en == 1'b1 && d == 8'hFF, "R1/R2 erased read", {en, d}, 9'h1FF);
    endtask

    task automatic t_page_write;
        logic [7:0] d, d2; logic en; int r, f;
        wr(11'h0C5, 8'h3C, 1'b1);
        wr(11'h107, 8'h5A, 1'b1);
        wait_busy(1'b1, r);
        chk(r == rel + 3 + T_BLW, "R5 busy rise cycle", r, rel + 3 + T_BLW);
        rd(11'h0C7, d, en);
        chk(d[7] == 1'b1, "R7 polling bit complement", d[7], 1);
        rd(11'h0C7, d2, en);
        chk(d2[6] != d[6], "R8 toggle bit flips", d2[6], !d[6]);
        wr(11'h0C5, 8'hFF, 1'b1);
        chk(busy_o == 1'b1, "R10 busy during program", busy_o, 1);
        wait_busy(1'b0, f);
        chk(f - r == T_PROG, "R6 program duration", f - r, T_PROG);
        rd(11'h0C5, d, en);
        chk(d == 8'h3C, "R9 ignored load during program", d, 8'h3C);
        rd(11'h0C7, d, en);
        chk(d == 8'h5A, "R3 later load uses first page", d, 8'h5A);
        chk(d[7] == 1'b0, "R7 true bit after program", d[7], 0);
        rd(11'h107, d, en);
        chk(d == 8'hFF, "R3 other page untouched", d, 8'hFF);
        rd(11'h0C6, d, en);
        chk(d == 8'hFF, "R6 unloaded byte kept", d, 8'hFF);
    endtask

    task automatic t_retrigger;
        int r, f; logic [7:0] d; logic en;
        wr(11'h300, 8'h81, 1'b1);
        repeat (10) @(negedge clk);
        wr(11'h301, 8'h82, 1'b1);
        wait_busy(1'b1, r);
        chk(r == rel + 3 + T_BLW, "R5 window restarted by load", r, rel + 3 + T_BLW);
        wait_busy(1'b0, f);
        rd(11'h300, d, en);
        chk(d == 8'h81, "R3 first byte of retriggered page", d, 8'h81);
    endtask

    task automatic t_oe_inhibit;
        logic [7:0] d; logic en;
        wr(11'h400, 8'h12, 1'b0);
        repeat (T_BLW + 10) @(negedge clk);
        chk(busy_o == 1'b0, "R4 no program when oe low", busy_o, 0);
        rd(11'h400, d, en);
        chk(d == 8'hFF, "R4 no load when oe low", d, 8'hFF);
    endtask

    task automatic t_abort;
        int r; logic [7:0] d; logic en;
        wr(11'h200, 8'h11, 1'b1);
        wait_busy(1'b1, r);
        @(negedge clk);
        res_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R11 busy cleared by reset", busy_o, 0);
        rd(11'h200, d, en);
        chk(en == 1'b0, "R11 output floats during reset", en, 0);
        res_n = 1'b1;
        repeat (T_PROG + 10) @(negedge clk);
        rd(11'h200, d, en);
        chk(d == 8'hFF && busy_o == 1'b0, "R11 array unchanged after abort", d, 8'hFF);
    endtask

    task automatic t_recovery;
        int r, f; logic [7:0] d; logic en;
        @(negedge clk);
        res_n = 1'b0;
        repeat (4) @(negedge clk);
        res_n = 1'b1;
        wr(11'h240, 8'h22, 1'b1);
        repeat (T_BLW + 10) @(negedge clk);
        chk(busy_o == 1'b0, "R12 load refused in recovery", busy_o, 0);
        rd(11'h240, d, en);
        chk(d == 8'hFF, "R12 array untouched by refused load", d, 8'hFF);
        wr(11'h240, 8'h22, 1'b1);
        wait_busy(1'b1, r);
        chk(r == rel + 3 + T_BLW, "R12 load accepted after recovery", r, rel + 3 + T_BLW);
        wait_busy(1'b0, f);
        rd(11'h240, d, en);
        chk(d == 8'h22, "R12 data stored after recovery", d, 8'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_page_write();
        t_retrigger();
        t_oe_inhibit();
        t_abort();
        t_recovery();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule